// File: doc/BRIEF.md
# Dual Timebase Prescaler Counter Unit

This block produces two free-running timebase counters for a timer coprocessor. Both run on one system clock. Counter A advances on a two-stage divider. The first stage is a free-running base counter that supplies either a divide-by-4 or a divide-by-32 tick. The second stage is a programmable divider that stretches that tick by 1, 2, 4 or 8. Counter B has two possible sources. One is the rising edges of an external pin, taken after a two-flop synchronizer and a three-cycle glitch filter. The other is a divide-by-8 system tick that is let through only while the filtered pin is high. Counter B also has its own programmable divide-by-1/2/4/8 stage.

There is no derived clock. Every divider output is a clock-enable pulse one system clock wide. A new divider code is taken into use only when the divider reaches its terminal count, so a code change never adds or drops a counter step. Software writes the configuration through a one-cycle strobe and reads it back at any time. The configuration holds an emulation-mode bit. Only the first write after reset can set that bit.

Top module: `tbase_dual`

## Requirements
- R1: After reset, count_a and count_b are 0, cfg_rdata is 0 and emu_mode is 0.
- R2: Setting cfg_we for one cycle stores cfg_wdata, and cfg_rdata shows it from the next cycle. The bit layout is: bit 0 selects the coarse first stage of counter A (0 = divide by 4, 1 = divide by 32). Bits 2:1 hold counter A's code and bits 4:3 hold counter B's code. Bit 5 selects the gated source for counter B. Bit 6 is the emulation bit.
- R3: In steady state, count_a steps by one every F * 2^codeA system clocks, where F is 4 or 32 as set by bit 0. Overall divides are therefore 4/8/16/32 or 32/64/128/256.
- R4: With bit 5 = 1 and the pin held high, count_b steps by one every 8 * 2^codeB system clocks.
- R5: With bit 5 = 1 and the pin held low, count_b does not change.
- R6: With bit 5 = 0 and codeB = 0, each pin pulse that stays high for at least three system clocks advances count_b by exactly one.
- R7: With bit 5 = 0, pin pulses shorter than three system clocks do not change count_b.
- R8: With bit 5 = 0, counter B's divider counts filtered rising edges. count_b steps once per 2^codeB edges. A new code is used from the divider's next terminal count onward.
- R9: Only the first configuration write after reset updates emu_mode. Later writes leave emu_mode and cfg_rdata bit 6 unchanged, while the other fields still update.
- R10: Each counter is CNT_W bits wide, steps by one at most per clock, and wraps from all-ones to 0.
- R11: A code written while a divider window is open leaves that window at its old length. The following windows use the new length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | One-cycle configuration write strobe |
| cfg_wdata | input | 7 | Configuration write data |
| cfg_rdata | output | 7 | Current configuration |
| ext_pin | input | 1 | External pin: count source or gate for counter B |
| count_a | output | CNT_W | Timebase counter A |
| count_b | output | CNT_W | Timebase counter B |
| emu_mode | output | 1 | Emulation-mode bit |

## Verification
Two functions can coincide: a configuration write that changes a divider code, and the terminal pulse of the window that is still open under the old code. The bench places a write eleven cycles into a 32-clock window of counter A. It then checks that this window still closes after 32 clocks and that the next window is 4 clocks. A second case exercises the emulation lock and the field updates together: a later write must change the code fields while the emulation bit stays where the first write left it.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

    localparam int CFG_W  = 7;
    localparam int CODE_W = 2;

    // Bit order of this struct is the software-visible layout.
    typedef struct packed {
        logic              emu;
        logic              gate;
        logic [CODE_W-1:0] code_b;
        logic [CODE_W-1:0] code_a;
        logic              coarse;
    } cfg_t;

endpackage

// File: rtl/tbase_cfg.sv
module tbase_cfg
    import tbase_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output cfg_t             cfg
);

    typedef struct packed {
        cfg_t cfg;
        logic locked;
    } st_t;

    st_t  st_d, st_q;
    cfg_t wr_cfg;

    assign wr_cfg = wr_data;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cfg     = wr_cfg;
            // emulation bit: only the first write after reset lands
            st_d.cfg.emu = st_q.locked ? st_q.cfg.emu : wr_cfg.emu;
            st_d.locked  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg = st_q.cfg;

endmodule

// File: rtl/tbase_tickgen.sv
module tbase_tickgen #(
    parameter int FINE_LOG2   = 2,
    parameter int COARSE_LOG2 = 5,
    parameter int GATE_LOG2   = 3
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_fine,
    output logic tick_coarse,
    output logic tick_gate
);

    localparam int MAX_FG = (FINE_LOG2 > GATE_LOG2) ? FINE_LOG2 : GATE_LOG2;
    localparam int BASE_W = (COARSE_LOG2 > MAX_FG) ? COARSE_LOG2 : MAX_FG;

    typedef struct packed {
        logic [BASE_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // every tap is one clock wide; all taps share one free-running count
    assign tick_fine   = &st_q.cnt[FINE_LOG2-1:0];
    assign tick_coarse = &st_q.cnt[COARSE_LOG2-1:0];
    assign tick_gate   = &st_q.cnt[GATE_LOG2-1:0];

endmodule

// File: rtl/tbase_extfilt.sv
module tbase_extfilt #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD        = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic level,
    output logic rise
);

    localparam int HW = $clog2(HOLD + 1);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   lvl;
        logic [HW-1:0]          run;
    } st_t;

    st_t  st_d, st_q;
    logic s_out;
    logic accept;

    assign s_out  = st_q.sync[SYNC_STAGES-1];
    assign accept = (s_out != st_q.lvl) && (st_q.run == HW'(HOLD - 1));

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[SYNC_STAGES-2:0], pin_in};
        if (s_out == st_q.lvl) begin
            st_d.run = '0;
        end else if (accept) begin
            st_d.lvl = s_out;
            st_d.run = '0;
        end else begin
            st_d.run = st_q.run + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.lvl;
    assign rise  = accept && s_out;

endmodule

// File: rtl/tbase_prescale.sv
module tbase_prescale #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic [CODE_W-1:0] code,
    output logic              pulse_out
);

    // the largest divide is 2^(2^CODE_W - 1)
    localparam int CW = (1 << CODE_W) - 1;

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [CODE_W-1:0] act;
    } st_t;

    st_t           st_d, st_q;
    logic [CW-1:0] lim;

    assign lim       = ~({CW{1'b1}} << st_q.act);
    assign pulse_out = tick_in && (st_q.cnt == lim);

    always_comb begin
        st_d = st_q;
        if (tick_in) begin
            if (pulse_out) begin
                st_d.cnt = '0;
                st_d.act = code;   // new code applies from the next window
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/tbase_dual.sv
module tbase_dual
    import tbase_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int FINE_LOG2   = 2,
    parameter int COARSE_LOG2 = 5,
    parameter int GATE_LOG2   = 3,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_HOLD   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             ext_pin,
    output logic [CNT_W-1:0] count_a,
    output logic [CNT_W-1:0] count_b,
    output logic             emu_mode
);

    localparam int N_TB = 2;

    cfg_t              cfg;
    logic              tick_fine, tick_coarse, tick_gate;
    logic              pin_level, pin_rise;
    logic [N_TB-1:0]   ps_tick, ps_pulse;
    logic [CODE_W-1:0] ps_code [N_TB];

    tbase_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (cfg_we),
        .wr_data(cfg_wdata),
        .cfg    (cfg)
    );

    tbase_tickgen #(
        .FINE_LOG2  (FINE_LOG2),
        .COARSE_LOG2(COARSE_LOG2),
        .GATE_LOG2  (GATE_LOG2)
    ) u_tick (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_fine  (tick_fine),
        .tick_coarse(tick_coarse),
        .tick_gate  (tick_gate)
    );

    tbase_extfilt #(
        .SYNC_STAGES(SYNC_STAGES),
        .HOLD       (FILT_HOLD)
    ) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_in(ext_pin),
        .level (pin_level),
        .rise  (pin_rise)
    );

    // source selection for the two prescalers
    assign ps_tick[0] = cfg.coarse ? tick_coarse : tick_fine;
    assign ps_tick[1] = cfg.gate   ? (tick_gate && pin_level) : pin_rise;
    assign ps_code[0] = cfg.code_a;
    assign ps_code[1] = cfg.code_b;

    for (genvar g = 0; g < N_TB; g++) begin : g_ps
        tbase_prescale #(
            .CODE_W(CODE_W)
        ) u_ps (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick_in  (ps_tick[g]),
            .code     (ps_code[g]),
            .pulse_out(ps_pulse[g])
        );
    end

    typedef struct packed {
        logic [CNT_W-1:0] cnt_a;
        logic [CNT_W-1:0] cnt_b;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ps_pulse[0]) st_d.cnt_a = st_q.cnt_a + 1'b1;
        if (ps_pulse[1]) st_d.cnt_b = st_q.cnt_b + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count_a   = st_q.cnt_a;
    assign count_b   = st_q.cnt_b;
    assign cfg_rdata = cfg;
    assign emu_mode  = cfg.emu;

endmodule

// File: rtl/tbase_dual_chk.sv
module tbase_dual_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [6:0]       cfg_wdata,
    input logic [6:0]       cfg_rdata,
    input logic             ext_pin,
    input logic [CNT_W-1:0] count_a,
    input logic [CNT_W-1:0] count_b,
    input logic             emu_mode
);

    logic [3:0] since_rst;
    logic [3:0] low_run;
    logic       wr_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= '0;
            low_run   <= '0;
            wr_seen   <= 1'b0;
        end else begin
            if (since_rst != 4'hF) since_rst <= since_rst + 1'b1;
            if (ext_pin)                low_run <= '0;
            else if (low_run != 4'hF)   low_run <= low_run + 1'b1;
            if (cfg_we) wr_seen <= 1'b1;
        end
    end

    // R10: counters advance by exactly one (modulo width) when they move
    a_r10_step_a: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 0 && count_a != $past(count_a)) |->
            (count_a - $past(count_a)) == CNT_W'(1));

    a_r10_step_b: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 0 && count_b != $past(count_b)) |->
            (count_b - $past(count_b)) == CNT_W'(1));

    // R2: write data is visible one cycle after the strobe
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> cfg_rdata[5:0] == $past(cfg_wdata[5:0]));

    // R9: once set, the emulation bit stays set
    a_r9_emu_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        emu_mode |=> emu_mode);

    // R9: writes after the first leave the emulation bit alone
    a_r9_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wr_seen) |=> $stable(emu_mode));

    // R5: gated source with the pin low long enough freezes counter B
    a_r5_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata[5] && low_run >= 4'd7) |-> $stable(count_b));

endmodule

bind tbase_dual tbase_dual_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata),
    .ext_pin  (ext_pin),
    .count_a  (count_a),
    .count_b  (count_b),
    .emu_mode (emu_mode)
);

// File: tb/tb_tbase_dual.sv
module tb_tbase_dual;

    localparam int CW  = 8;
    localparam int MAX = (1 << CW) - 1;

    // {cfg byte, expected period A, expected period B (gated, pin high)}
    localparam logic [31:0] VEC [6] = '{
        {8'h20, 12'd4,   12'd8 },
        {8'h23, 12'd64,  12'd8 },
        {8'h2C, 12'd16,  12'd16},
        {8'h3E, 12'd32,  12'd64},
        {8'h37, 12'd256, 12'd32},
        {8'h29, 12'd32,  12'd16}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [6:0]    cfg_wdata = '0;
    logic [6:0]    cfg_rdata;
    logic          ext_pin = 1'b0;
    logic [CW-1:0] count_a, count_b;
    logic          emu_mode;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    tbase_dual #(.CNT_W(CW)) dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata),
        .ext_pin  (ext_pin),
        .count_a  (count_a),
        .count_b  (count_b),
        .emu_mode (emu_mode)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] cur(input bit sel_b);
        return sel_b ? count_b : count_a;
    endfunction

    task automatic wr(input logic [6:0] d);
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_we = 1'b0;
    endtask

    task automatic do_reset;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // clocks between two successive steps of the selected counter
    task automatic period(input bit sel_b, output int p);
        logic [CW-1:0] v;
        int g;
        v = cur(sel_b); g = 0;
        while (cur(sel_b) == v && g < 4000) begin @(negedge clk); g++; end
        v = cur(sel_b); p = 0;
        while (cur(sel_b) == v && p < 4000) begin @(negedge clk); p++; end
    endtask

    task automatic pulse(input int hi, input int lo);
        @(negedge clk); ext_pin = 1'b1;
        repeat (hi) @(negedge clk);
        ext_pin = 1'b0;
        repeat (lo) @(negedge clk);
    endtask

    initial begin
        int p;
        int b0;
        logic [CW-1:0] v;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 count_a", int'(count_a), 0);
        check("R1 count_b", int'(count_b), 0);
        check("R1 cfg_rdata", int'(cfg_rdata), 0);
        check("R1 emu_mode", int'(emu_mode), 0);

        // R9 first write sets emulation, later write cannot clear it
        wr(7'h40);
        check("R9 emu set by first write", int'(emu_mode), 1);
        wr(7'h06);
        check("R9 emu kept", int'(emu_mode), 1);
        check("R9 fields still update", int'(cfg_rdata), 'h46);

        // R9 first write clears, later write cannot set
        do_reset;
        check("R1 emu after reset", int'(emu_mode), 0);
        wr(7'h00);
        wr(7'h40);
        check("R9 emu locked at 0", int'(emu_mode), 0);

        // R2 R3 R4 vector table, pin held high for the gated source
        ext_pin = 1'b1;
        for (int i = 0; i < 6; i++) begin
            wr(VEC[i][30:24]);
            check("R2 readback", int'(cfg_rdata[5:0]), int'(VEC[i][29:24]));
            period(1'b0, p); period(1'b0, p); period(1'b0, p);
            check("R3 period A", p, int'(VEC[i][23:12]));
            period(1'b1, p); period(1'b1, p); period(1'b1, p);
            check("R4 period B gated", p, int'(VEC[i][11:0]));
        end

        // R11 code change inside an open window of counter A
        wr(7'h06);
        period(1'b0, p); period(1'b0, p);
        check("R11 old period", p, 32);
        v = count_a;
        while (count_a == v) @(negedge clk);
        v = count_a; p = 0;
        repeat (10) begin @(negedge clk); p++; end
        wr(7'h00); p += 2;
        while (count_a == v && p < 4000) begin @(negedge clk); p++; end
        check("R11 open window keeps old length", p, 32);
        period(1'b0, p);
        check("R11 new length next", p, 4);

        // R5 gated source, pin low
        wr(7'h20);
        ext_pin = 1'b0;
        repeat (12) @(negedge clk);
        b0 = int'(count_b);
        repeat (100) @(negedge clk);
        check("R5 count_b frozen", int'(count_b), b0);

        // R6 R7 R8 external edge source
        wr(7'h00);
        repeat (10) @(negedge clk);
        b0 = int'(count_b);
        repeat (5) pulse(6, 6);
        repeat (10) @(negedge clk);
        check("R6 one step per pulse", int'(count_b - CW'(b0)), 5);
        b0 = int'(count_b);
        repeat (5) pulse(2, 6);
        repeat (10) @(negedge clk);
        check("R7 short pulses ignored", int'(count_b - CW'(b0)), 0);
        wr(7'h08);
        b0 = int'(count_b);
        repeat (6) pulse(6, 6);
        repeat (10) @(negedge clk);
        check("R8 divide-by-2 of edges", int'(count_b - CW'(b0)), 3);

        // R10 wrap of both counters
        wr(7'h20);
        ext_pin = 1'b1;
        p = 0;
        while (count_a != CW'(MAX) && p < 10000) begin @(negedge clk); p++; end
        while (count_a == CW'(MAX) && p < 10000) begin @(negedge clk); p++; end
        check("R10 count_a wraps", int'(count_a), 0);
        p = 0;
        while (count_b != CW'(MAX) && p < 10000) begin @(negedge clk); p++; end
        while (count_b == CW'(MAX) && p < 10000) begin @(negedge clk); p++; end
        check("R10 count_b wraps", int'(count_b), 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(8 * 190000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule